// File: doc/BRIEF.md
# Two-Channel Pulse Coincidence Detector

This block decides whether two detector channels saw pulses that belong to the same physical event. Each channel supplies two flags, both synchronous to the sampling clock. One is a hysteresis threshold flag that is high for the length of a pulse. The other is an over-amplitude flag that marks pulses that are too large to trust. The detector looks only at the leading edges of the threshold flags. The first edge opens a window whose length, in clock cycles, is given on an input; a value of 15 gives 120 ns at an 8 ns clock. If the other channel's edge arrives inside that window, the pair becomes a candidate.

The detector then follows the candidate until either threshold flag drops. An over-amplitude flag on either channel at any time from the first leading edge up to and including that end cycle discards the event. A candidate that survives produces a single-cycle pulse on the output, which a downstream counter can tally. After any window expiry or finished event, the detector stays disarmed until both threshold flags are low again. This stops a single long pulse from opening a fresh window.

Top module: `coinc_detect`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `coinc_o` is 0 and the detector is idle.
- R2: A leading edge on one threshold flag followed by a leading edge on the other, k clock edges later with 1 <= k <= `win_len_i`, forms a candidate. Either channel may lead.
- R3: If the second leading edge arrives more than `win_len_i` edges after the first, no event is produced from that pair.
- R4: Leading edges on both threshold flags at the same clock edge form a candidate with zero separation, including when `win_len_i` is 0.
- R5: For a candidate, `coinc_o` rises in the cycle after the first clock edge at which either threshold flag is sampled low, and at no earlier point.
- R6: Every event drives `coinc_o` high for exactly one clock cycle.
- R7: An over-amplitude flag high on either channel at any sampled edge from the first leading edge through the end edge of R5 discards the event, so `coinc_o` stays 0.
- R8: After a window expiry or the end of a candidate, leading edges are ignored until an edge at which both threshold flags are low. After that edge, a new pair is detected normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| win_len_i | input | WIN_W | Coincidence window length in clock cycles |
| thr_a_i | input | 1 | Channel A hysteresis threshold flag |
| thr_b_i | input | 1 | Channel B hysteresis threshold flag |
| ovr_a_i | input | 1 | Channel A over-amplitude flag |
| ovr_b_i | input | 1 | Channel B over-amplitude flag |
| coinc_o | output | 1 | One-cycle valid coincidence pulse |

## Verification
The one registered result is the event pulse. It is due one cycle after the clock edge that samples the first falling threshold flag. Window acceptance is decided at the edge that samples the second leading edge, so the separation in edges is exactly the number of cycles the bench waits between the two rising drives. The bench drives inputs just after a rising edge and reads `coinc_o` just after the following one, which lands on the cycle the pulse is due. A monitor on the falling edge counts every pulse and flags any pulse that lasts two cycles. Each scenario therefore checks both the due cycle and the pulse count over the whole scenario.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  localparam int NCH = 2;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_AWAIT_B = 3'd1,
    ST_AWAIT_A = 3'd2,
    ST_TRACK   = 3'd3,
    ST_REARM   = 3'd4
  } cd_state_e;
endpackage

// File: rtl/coinc_edge.sv
module coinc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= flag_i;
  end

  assign rise_o = flag_i & ~prev_q;
endmodule

// File: rtl/coinc_win_timer.sv
module coinc_win_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             inc_i,
  output logic [WIN_W-1:0] cnt_o
);
  logic [WIN_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | inc_i;
    if (load_i) cnt_d = WIN_W'(1);
    else        cnt_d = cnt_q + WIN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/coinc_veto.sv
module coinc_veto (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic acc_i,
  input  logic ovr_any_i,
  output logic veto_now_o
);
  logic veto_d, veto_q, veto_en;

  always_comb begin
    veto_en = start_i | acc_i;
    if (start_i) veto_d = ovr_any_i;
    else         veto_d = veto_q | ovr_any_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       veto_q <= 1'b0;
    else if (veto_en) veto_q <= veto_d;
  end

  assign veto_now_o = veto_q | ovr_any_i;
endmodule

// File: rtl/coinc_fsm.sv
module coinc_fsm
  import coinc_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   rise_i,
  input  logic [NCH-1:0]   thr_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [WIN_W-1:0] cnt_i,
  input  logic             veto_now_i,
  output logic             cnt_load_o,
  output logic             cnt_inc_o,
  output logic             veto_start_o,
  output logic             veto_acc_o,
  output logic             coinc_o,
  output cd_state_e        st_o
);
  cd_state_e st_q, st_d;
  logic      fire_d, fire_q;
  logic      in_win, expired, ended, all_low;

  always_comb begin
    in_win  = (cnt_i <= win_len_i);
    expired = (cnt_i >= win_len_i);
    ended   = ~&thr_i;
    all_low = ~|thr_i;
  end

  always_comb begin
    st_d         = st_q;
    cnt_load_o   = 1'b0;
    cnt_inc_o    = 1'b0;
    veto_start_o = 1'b0;
    veto_acc_o   = 1'b0;
    fire_d       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        veto_start_o = |rise_i;
        if (&rise_i) begin
          st_d = ST_TRACK;
        end else if (rise_i[0]) begin
          st_d       = ST_AWAIT_B;
          cnt_load_o = 1'b1;
        end else if (rise_i[1]) begin
          st_d       = ST_AWAIT_A;
          cnt_load_o = 1'b1;
        end
      end
      ST_AWAIT_B: begin
        veto_acc_o = 1'b1;
        if (rise_i[1] && in_win) st_d = ST_TRACK;
        else if (expired)        st_d = ST_REARM;
        else                     cnt_inc_o = 1'b1;
      end
      ST_AWAIT_A: begin
        veto_acc_o = 1'b1;
        if (rise_i[0] && in_win) st_d = ST_TRACK;
        else if (expired)        st_d = ST_REARM;
        else                     cnt_inc_o = 1'b1;
      end
      ST_TRACK: begin
        veto_acc_o = 1'b1;
        if (ended) begin
          fire_d = ~veto_now_i;
          st_d   = ST_REARM;
        end
      end
      ST_REARM: begin
        if (all_low) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fire_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fire_q <= fire_d;
    end
  end

  assign coinc_o = fire_q;
  assign st_o    = st_q;
endmodule

// File: rtl/coinc_detect.sv
module coinc_detect
  import coinc_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic             thr_a_i,
  input  logic             thr_b_i,
  input  logic             ovr_a_i,
  input  logic             ovr_b_i,
  output logic             coinc_o
);
  logic [NCH-1:0]   thr_v, rise_v;
  logic [WIN_W-1:0] cnt;
  logic             cnt_load, cnt_inc, veto_start, veto_acc, veto_now, ovr_any;
  cd_state_e        st;

  assign thr_v   = {thr_b_i, thr_a_i};
  assign ovr_any = ovr_a_i | ovr_b_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_edge
    coinc_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (thr_v[ch]),
      .rise_o (rise_v[ch])
    );
  end

  coinc_win_timer #(.WIN_W(WIN_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cnt_load),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  coinc_veto u_veto (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (veto_start),
    .acc_i      (veto_acc),
    .ovr_any_i  (ovr_any),
    .veto_now_o (veto_now)
  );

  coinc_fsm #(.WIN_W(WIN_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_i       (rise_v),
    .thr_i        (thr_v),
    .win_len_i    (win_len_i),
    .cnt_i        (cnt),
    .veto_now_i   (veto_now),
    .cnt_load_o   (cnt_load),
    .cnt_inc_o    (cnt_inc),
    .veto_start_o (veto_start),
    .veto_acc_o   (veto_acc),
    .coinc_o      (coinc_o),
    .st_o         (st)
  );
endmodule

module coinc_detect_chk
  import coinc_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           thr_a_i,
  input logic           thr_b_i,
  input logic           ovr_a_i,
  input logic           ovr_b_i,
  input logic           coinc_o,
  input logic [NCH-1:0] rise_v,
  input cd_state_e      st
);
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    coinc_o |=> !coinc_o);

  a_r5_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    coinc_o |-> $past(!thr_a_i || !thr_b_i));

  a_r7_no_ovr_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    coinc_o |-> !$past(ovr_a_i || ovr_b_i));

  a_r8_hold_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REARM && (thr_a_i || thr_b_i)) |=> (st == ST_REARM));

  a_r4_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && rise_v[0] && rise_v[1]) |=> (st == ST_TRACK));

  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!coinc_o);
  end
endmodule

bind coinc_detect coinc_detect_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .thr_a_i (thr_a_i),
  .thr_b_i (thr_b_i),
  .ovr_a_i (ovr_a_i),
  .ovr_b_i (ovr_b_i),
  .coinc_o (coinc_o),
  .rise_v  (rise_v),
  .st      (st)
);

// File: tb/tb_coinc_detect.sv
`timescale 1ns/1ps
module tb_coinc_detect;
  localparam int WIN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [WIN_W-1:0] win_len;
  logic             thr_a, thr_b, ovr_a, ovr_b;
  logic             coinc;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int wide   = 0;
  logic prev_coinc = 1'b0;

  always #4 clk = ~clk;

  coinc_detect #(.WIN_W(WIN_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_len_i (win_len),
    .thr_a_i   (thr_a),
    .thr_b_i   (thr_b),
    .ovr_a_i   (ovr_a),
    .ovr_b_i   (ovr_b),
    .coinc_o   (coinc)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (coinc) pulses++;
      if (coinc && prev_coinc) wide++;
      prev_coinc <= coinc;
    end else begin
      prev_coinc <= 1'b0;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_lead(bit b_lead, logic v);
    if (b_lead) thr_b = v; else thr_a = v;
  endtask

  task automatic set_other(bit b_lead, logic v);
    if (b_lead) thr_a = v; else thr_b = v;
  endtask

  // ovr_mode: 0 none, 1 at first leading edge, 2 mid-pulse, 3 at end edge
  task automatic run_pair(string req, int sep, bit b_lead, int hold,
                          int ovr_mode, bit exp_evt);
    int p0 = pulses;
    int w0 = wide;
    set_lead(b_lead, 1'b1);
    if (ovr_mode == 1) ovr_b = 1'b1;
    if (sep == 0) begin
      set_other(b_lead, 1'b1);
      tick();
      ovr_b = 1'b0;
    end else begin
      tick();
      ovr_b = 1'b0;
      repeat (sep - 1) tick();
      set_other(b_lead, 1'b1);
      tick();
    end
    if (ovr_mode == 2) begin
      ovr_a = 1'b1;
      tick();
      ovr_a = 1'b0;
      repeat (hold - 1) tick();
    end else begin
      repeat (hold) tick();
    end
    set_lead(b_lead, 1'b0);
    if (ovr_mode == 3) ovr_a = 1'b1;
    tick();
    check({req, " due cycle"}, coinc, exp_evt);
    ovr_a = 1'b0;
    tick();
    check("R6 pulse low after one cycle", coinc, 0);
    set_other(b_lead, 1'b0);
    repeat (3) tick();
    check({req, " pulse count"}, pulses - p0, exp_evt);
    check("R6 no wide pulse", wide - w0, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    thr_a = 1'b0; thr_b = 1'b0; ovr_a = 1'b0; ovr_b = 1'b0;
    win_len = WIN_W'(15);
    repeat (3) tick();
    check("R1 output low in reset", coinc, 0);
    rst_n = 1'b1;
    tick();
    check("R1 output low after release", coinc, 0);
  endtask

  task automatic t_expire_long_pulse();
    int p0 = pulses;
    win_len = WIN_W'(3);
    thr_a = 1'b1;
    repeat (10) tick();
    thr_b = 1'b1;
    repeat (3) tick();
    thr_a = 1'b0;
    tick();
    check("R8 no event from long pulse", coinc, 0);
    repeat (2) tick();
    thr_b = 1'b0;
    repeat (3) tick();
    check("R8 no pulse after expiry", pulses - p0, 0);
    run_pair("R8 rearmed pair", 2, 1'b0, 4, 0, 1'b1);
  endtask

  task automatic t_rise_while_other_high();
    int p0 = pulses;
    win_len = WIN_W'(15);
    thr_a = 1'b1; tick();
    thr_b = 1'b1; repeat (2) tick();
    thr_a = 1'b0; tick();
    check("R5 first event fires", coinc, 1);
    repeat (2) tick();
    thr_a = 1'b1; repeat (3) tick();
    thr_a = 1'b0; repeat (3) tick();
    thr_b = 1'b0; repeat (3) tick();
    check("R8 second rise ignored while disarmed", pulses - p0, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    win_len = WIN_W'(15);
    run_pair("R2 A leads by 5", 5, 1'b0, 4, 0, 1'b1);
    run_pair("R2 B leads by 7", 7, 1'b1, 6, 0, 1'b1);
    run_pair("R2 edge at window 15", 15, 1'b0, 3, 0, 1'b1);
    run_pair("R3 one past window 15", 16, 1'b0, 3, 0, 1'b0);
    run_pair("R5 long overlap", 1, 1'b1, 20, 0, 1'b1);
    run_pair("R4 same edge", 0, 1'b0, 5, 0, 1'b1);
    win_len = WIN_W'(3);
    run_pair("R2 edge at window 3", 3, 1'b1, 3, 0, 1'b1);
    run_pair("R3 one past window 3", 4, 1'b1, 3, 0, 1'b0);
    win_len = WIN_W'(0);
    run_pair("R4 same edge window 0", 0, 1'b1, 2, 0, 1'b1);
    run_pair("R3 separation 1 window 0", 1, 1'b0, 2, 0, 1'b0);
    win_len = WIN_W'(15);
    run_pair("R7 ovr at first edge", 4, 1'b0, 4, 1, 1'b0);
    run_pair("R7 ovr mid pulse", 2, 1'b1, 5, 2, 1'b0);
    run_pair("R7 ovr at end edge", 0, 1'b0, 5, 3, 1'b0);
    run_pair("R7 clean after veto", 3, 1'b0, 4, 0, 1'b1);
    t_expire_long_pulse();
    t_rise_while_other_high();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule